// File: doc/BRIEF.md
# Single-precision to minifloat converter

This block narrows an IEEE single-precision word to a compact floating-point word made of one sign bit, `EXP_W` exponent bits and `MAN_W` mantissa bits. Typical targets are 8-bit (4/3), 12-bit (5/6) and 16-bit (5/10) formats. These formats store weights and activations cheaply in low-precision neural-network datapaths, while the arithmetic stays in single precision.

The fraction is rounded to nearest with ties to even. The exponent is re-biased. A carry out of the rounded mantissa bumps the exponent. Values below the normal exponent range are shifted into a denormal form. Values beyond the top of the range saturate to signed infinity. Special inputs are handled apart from this path: zero or single-precision denormals, infinity, and NaN.

A result appears one clock after a valid input, together with its own valid strobe.

Top module: `f32_to_minifloat`

## Requirements
- R1: The output sign bit (bit `EXP_W+MAN_W`) always equals bit 31 of the input word.
- R2: For a finite normal input whose rounding causes no carry, the output exponent field equals the input exponent field (bits 30:23) minus 127 plus 2^(EXP_W-1)-1. The output mantissa field (low `MAN_W` bits) equals the input fraction bits 22 down to 23-MAN_W.
- R3: The rounding increment is G and (L or R or T). L is fraction bit 23-MAN_W. G is bit 22-MAN_W. R is bit 21-MAN_W. T is the OR of the fraction bits below R.
- R4: When the increment carries out of the `MAN_W`-bit field, the mantissa field becomes zero and the output exponent is one higher.
- R5: When the computed exponent is 2^EXP_W-1 or more, the output is infinity with the input's sign: exponent all ones, mantissa zero.
- R6: When the computed exponent e is negative, let v = 2^MAN_W + rounded mantissa and k = -e. The low `EXP_W+MAN_W` bits become (v >> k) + bit k-1 of v. That bit is 0 when k > MAN_W+1. A carry from this sum lands in exponent bit 0.
- R7: A computed exponent of exactly zero yields exponent field zero, with the rounded mantissa kept unchanged.
- R8: A finite input never yields an all-ones output exponent with a nonzero mantissa.
- R9: An input with exponent field 255 and nonzero fraction yields exponent all ones with only the mantissa MSB set. An input with exponent field 255 and zero fraction yields signed infinity.
- R10: An input with exponent field zero yields signed zero.
- R11: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. `out_word` holds its value while no input is valid.
- R12: While `rst` is high at a clock edge, `out_valid` and `out_word` are cleared to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | 32 | Single-precision input |
| out_valid | output | 1 | Output word is valid |
| out_word | output | 1+EXP_W+MAN_W | Converted minifloat |

## Verification
A mantissa rounding carry can occur in the same cycle as an exponent that sits on a range boundary. The carry can push the largest finite exponent into infinity. It can also lift an exponent of -1 to zero, or make an input from deeper down take the denormal path with a zeroed mantissa. The bench drives fractions with all kept bits set and G set at each of these exponents. It compares the output against values worked out by hand from the rules above, so a wrongly ordered carry and range test shows up as a wrong code.

// File: rtl/mf_pkg.sv
package mf_pkg;
  localparam int F32_W      = 32;
  localparam int F32_EXP_W  = 8;
  localparam int F32_FRAC_W = 23;
  localparam int F32_BIAS   = 127;
  localparam int EXP_CALC_W = 12;
  typedef logic [EXP_CALC_W-1:0] exp_calc_t;
endpackage

// File: rtl/mf_round.sv
module mf_round
  import mf_pkg::*;
#(
  parameter int MAN_W = 3
) (
  input  logic [F32_FRAC_W-1:0] frac,
  output logic [MAN_W-1:0]      man,
  output logic                  carry
);
  localparam int DROP = F32_FRAC_W - MAN_W;

  logic [MAN_W-1:0] kept;
  logic             g_bit, l_bit, r_bit, t_bit, inc;
  logic [MAN_W:0]   sum;

  always_comb begin
    kept  = frac[F32_FRAC_W-1:DROP];
    l_bit = frac[DROP];
    g_bit = frac[DROP-1];
    r_bit = frac[DROP-2];
    t_bit = |frac[DROP-3:0];
    inc   = g_bit & (l_bit | r_bit | t_bit);
    sum   = {1'b0, kept} + {{MAN_W{1'b0}}, inc};
    man   = sum[MAN_W-1:0];
    carry = sum[MAN_W];
  end
endmodule

// File: rtl/mf_rebias.sv
module mf_rebias
  import mf_pkg::*;
#(
  parameter int EXP_W = 4
) (
  input  logic [F32_EXP_W-1:0] exp_in,
  input  logic                 carry,
  output exp_calc_t            exp_out
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  always_comb begin
    exp_out = exp_calc_t'(exp_in) + exp_calc_t'(BIAS) + exp_calc_t'(carry)
            - exp_calc_t'(F32_BIAS);
  end
endmodule

// File: rtl/mf_denorm.sv
module mf_denorm
  import mf_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int MAN_W = 3
) (
  input  logic [MAN_W-1:0]       man,
  input  exp_calc_t              exp_neg,
  output logic [EXP_W+MAN_W-1:0] field
);
  exp_calc_t      k;
  logic [MAN_W:0] v, sh, gsh;
  logic           gu;

  always_comb begin
    k   = exp_calc_t'(0) - exp_neg;
    v   = {1'b1, man};
    sh  = '0;
    gu  = 1'b0;
    gsh = '0;
    if (k <= exp_calc_t'(MAN_W + 1)) begin
      sh  = v >> k;
      gsh = v >> (k - exp_calc_t'(1));
      gu  = gsh[0];
    end
    field = {{(EXP_W-1){1'b0}}, sh} + {{(EXP_W+MAN_W-1){1'b0}}, gu};
  end
endmodule

// File: rtl/f32_to_minifloat.sv
module f32_to_minifloat
  import mf_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int MAN_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [31:0]            in_word,
  output logic                   out_valid,
  output logic [EXP_W+MAN_W:0]   out_word
);
  localparam int        OUT_W    = 1 + EXP_W + MAN_W;
  localparam exp_calc_t EXP_ONES = exp_calc_t'((1 << EXP_W) - 1);

  logic                  sgn;
  logic [F32_EXP_W-1:0]  ef;
  logic [F32_FRAC_W-1:0] frac;
  logic [MAN_W-1:0]      man_r;
  logic                  carry;
  exp_calc_t             em;
  logic                  em_neg, em_sat;
  logic [EXP_W+MAN_W-1:0] den_field;
  logic [OUT_W-1:0]      nxt;

  assign sgn  = in_word[31];
  assign ef   = in_word[30:23];
  assign frac = in_word[22:0];

  mf_round #(.MAN_W(MAN_W)) u_round (
    .frac(frac), .man(man_r), .carry(carry)
  );

  mf_rebias #(.EXP_W(EXP_W)) u_rebias (
    .exp_in(ef), .carry(carry), .exp_out(em)
  );

  mf_denorm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_denorm (
    .man(man_r), .exp_neg(em), .field(den_field)
  );

  assign em_neg = em[EXP_CALC_W-1];
  assign em_sat = !em_neg && (em >= EXP_ONES);

  always_comb begin
    nxt = '0;
    nxt[OUT_W-1] = sgn;
    if (ef == '1) begin
      nxt[EXP_W+MAN_W-1:MAN_W] = '1;
      nxt[MAN_W-1] = (frac != '0);
    end else if (ef == '0) begin
      nxt[EXP_W+MAN_W-1:0] = '0;
    end else if (em_sat) begin
      nxt[EXP_W+MAN_W-1:MAN_W] = '1;
    end else if (em_neg) begin
      nxt[EXP_W+MAN_W-1:0] = den_field;
    end else begin
      nxt[EXP_W+MAN_W-1:0] = {em[EXP_W-1:0], man_r};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= nxt;
    end
  end

  a_r1_sign_copy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_word[OUT_W-1] == $past(in_word[31]));

  a_r11_valid_follow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rst) |=> out_valid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !rst) |=> !out_valid);

  a_r8_no_alias: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_word[EXP_W+MAN_W-1:MAN_W] == '1 && $past(in_word[30:23]) != 8'hFF)
      |-> out_word[MAN_W-1:0] == '0);

  a_r9_nan_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_word[30:23]) == 8'hFF && $past(in_word[22:0]) != '0)
      |-> (out_word[EXP_W+MAN_W-1:MAN_W] == '1 && out_word[MAN_W-1]));

  a_r10_zero_in: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_word[30:23]) == 8'h00) |-> out_word[EXP_W+MAN_W-1:0] == '0);
endmodule

// File: tb/f32_to_minifloat_tb_top.sv
module f32_to_minifloat_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic [7:0]  out_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] q_exp[$];
  logic [31:0] q_in[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  f32_to_minifloat #(.EXP_W(4), .MAN_W(3)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [7:0] e, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    q_in.push_back(w);
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 32'hDEADBEEF;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R11 extra result", {24'h0, out_word}, 32'h0);
      end else begin
        logic [7:0] e;
        logic [31:0] w;
        string t;
        e = q_exp.pop_front();
        w = q_in.pop_front();
        t = q_tag.pop_front();
        check(out_word == e, $sformatf("%s in=%h", t, w), {24'h0, out_word}, {24'h0, e});
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R12 valid after reset", {31'h0, out_valid}, 32'h0);
    check(out_word == 8'h00, "R12 word after reset", {24'h0, out_word}, 32'h0);

    send(32'h3F800000, 8'h38, "R2 one");
    send(32'hC0000000, 8'hC0, "R1 minus two");
    send(32'h3FC00000, 8'h3C, "R2 one and half");
    send(32'h3F880000, 8'h38, "R3 tie even down");
    send(32'h3F980000, 8'h3A, "R3 tie odd up");
    send(32'h3F880001, 8'h39, "R3 sticky up");
    send(32'h3F8C0000, 8'h39, "R3 round bit up");
    send(32'h3FF80000, 8'h40, "R4 carry to exp");
    send(32'h43700000, 8'h77, "R8 largest finite");
    send(32'h437C0000, 8'h78, "R5 carry into inf");
    send(32'hC9742400, 8'hF8, "R5 big negative");
    idle();
    idle();
    check(out_valid == 1'b0, "R11 idle no valid", {31'h0, out_valid}, 32'h0);
    check(out_word == 8'hF8, "R11 hold word", {24'h0, out_word}, 32'hF8);

    send(32'h7F800000, 8'h78, "R9 plus inf");
    send(32'hFF800000, 8'hF8, "R9 minus inf");
    send(32'h7FC00000, 8'h7C, "R9 nan");
    send(32'hFF800001, 8'hFC, "R9 neg nan");
    send(32'h00000000, 8'h00, "R10 zero");
    send(32'h80000000, 8'h80, "R10 neg zero");
    send(32'h00000001, 8'h00, "R10 f32 denormal");
    send(32'h3C200000, 8'h02, "R7 exp zero");
    send(32'h3BF80000, 8'h00, "R7 carry lifts to zero");
    send(32'h3BC00000, 8'h06, "R6 k1 no guard");
    send(32'h3BD00000, 8'h07, "R6 k1 guard");
    send(32'h3BF00000, 8'h08, "R6 carry to exp bit");
    send(32'h3B780000, 8'h04, "R6 carry then denormal");
    send(32'h3AE00000, 8'h02, "R6 k3");
    send(32'h3A000000, 8'h01, "R6 k4 guard only");
    send(32'h39800000, 8'h00, "R6 k5 flush");
    send(32'h00800000, 8'h00, "R6 deep underflow");
    send(32'h80800000, 8'h80, "R1 R6 neg underflow");
    idle();
    idle();
    idle();
    check(q_exp.size() == 0, "R11 all results seen", q_exp.size(), 32'h0);

    send(32'h3F800000, 8'h38, "R12 pre reset");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    void'(q_exp.pop_front());
    void'(q_in.pop_front());
    void'(q_tag.pop_front());
    @(negedge clk);
    check(out_valid == 1'b0, "R12 reset clears valid", {31'h0, out_valid}, 32'h0);
    check(out_word == 8'h00, "R12 reset clears word", {24'h0, out_word}, 32'h0);
    rst = 1'b0;
    idle();
    summary();
  end
endmodule